// File: doc/BRIEF.md
# Thermal Sensor Code to Temperature Converter

This block turns raw thermal sensor readings into a junction temperature in millidegrees Celsius. After a start request it collects eight sensor codes from a valid-qualified stream and averages them. It then removes the sensor's curvature with an integer rational correction and maps the corrected code onto temperature using a two-point calibration. Finally it rounds the result up onto a 500 millidegree grid and reports it as a signed 32-bit value together with a one-cycle done pulse.

Two 32-bit calibration words are sampled when a conversion is accepted. A word whose valid flag is clear is replaced by a built-in default. The three divisions in the flow share one multi-cycle restoring divider, so a conversion takes roughly a hundred cycles after the last sample arrives. If the two calibration points coincide, the conversion ends with an error flag instead of a division by zero.

Top module: `tsense_conv`

## Requirements
- R1: After reset, busy_o, done_o and err_o are 0 and temp_o is 0.
- R2: A conversion collects exactly eight samples, taken only in cycles where sample_valid_i is 1. Only bits 11:0 of sample_i are used, and the average is the sum divided by eight with truncation.
- R3: The corrected code is (avg × 1000000) / (1000000 + 13 × avg), using truncating unsigned division.
- R4: The temperature is (corr − c1) × (165000 / (c0 − c1)) − 40000. The quotient is taken first as a truncating 32-bit unsigned division, so when c0 < c1 the quotient is 0. The product is kept modulo 2^32 as two's complement.
- R5: Each calibration word is used as bits 11:0 when bit 31 is 1. Otherwise c0 is 3148 and c1 is 503.
- R6: temp_o is the smallest multiple of 500 that is greater than or equal to the intermediate value, for negative values as well.
- R7: done_o is high for exactly one cycle per finished conversion. temp_o and err_o hold their values until the next conversion finishes.
- R8: busy_o is high from the cycle after start_i is accepted until done_o. A start_i while busy is ignored. A start_i in the done_o cycle is accepted.
- R9: If c0 equals c1, the conversion finishes with err_o = 1 and temp_o = 0.
- R10: sample_valid_i outside the collection phase, including in the cycle that accepts start_i, has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a conversion; accepted when idle |
| sample_valid_i | input | 1 | sample_i carries a sensor code |
| sample_i | input | 16 | Raw sensor code, bits 11:0 used |
| cal0_i | input | 32 | Upper calibration word: bit 31 valid, bits 11:0 value |
| cal1_i | input | 32 | Lower calibration word: bit 31 valid, bits 11:0 value |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| err_o | output | 1 | Last conversion had equal calibration points |
| temp_o | output | 32 | Temperature in millidegrees Celsius, two's complement |

## Verification
A new start can arrive in the very cycle the done pulse is shown. The bench raises start_i as soon as it sees done_o and then expects a second, complete conversion with its own correct result. A sample strobe can also coincide with the accepting start. The bench drives a junk sample in that cycle and in idle cycles, and requires the result to depend only on the eight samples that follow. A start pulse during the busy phase is judged by an unchanged result and by busy_o staying low afterwards.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned SCALE    = 1000000;
  localparam int unsigned CURV_K   = 13;
  localparam int unsigned SPAN_MC  = 165000;
  localparam int unsigned OFFS_MC  = 40000;
  localparam int unsigned GRAN_MC  = 500;
  localparam int unsigned DEF_CAL0 = 3148;
  localparam int unsigned DEF_CAL1 = 503;
  localparam int unsigned CAL_VLD  = 31;

  typedef enum logic [3:0] {
    S_IDLE, S_COLLECT, S_CORR_GO, S_CORR_WT, S_GAIN_GO, S_GAIN_WT,
    S_MUL, S_RND_GO, S_RND_WT
  } conv_state_e;
endpackage

// File: rtl/tsc_div.sv
module tsc_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int CW = $clog2(W);

  logic          run_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  quo_q, rem_q, dvs_q;
  logic [W:0]    shift_w, trial_w;

  assign shift_w = {rem_q, quo_q[W-1]};
  assign trial_w = shift_w - {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dvs_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        quo_q <= dividend_i;
        rem_q <= '0;
        dvs_q <= divisor_i;
      end else if (run_q) begin
        // restoring step: keep trial when non-negative
        if (!trial_w[W]) rem_q <= trial_w[W-1:0];
        else             rem_q <= shift_w[W-1:0];
        quo_q <= {quo_q[W-2:0], ~trial_w[W]};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(W-1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = run_q;
  assign done_o = done_q;
  assign quot_o = quo_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/tsc_acc.sv
module tsc_acc #(
  parameter int DW = 12,
  parameter int N  = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clr_i,
  input  logic                         en_i,
  input  logic [DW-1:0]                data_i,
  output logic [DW+$clog2(N)-1:0]      sum_o,
  output logic                         full_o
);
  localparam int SW   = DW + $clog2(N);
  localparam int CNTW = $clog2(N + 1);

  logic [SW-1:0]   sum_q;
  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (en_i && !full_o) begin
      sum_q <= sum_q + SW'(data_i);
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign full_o = (cnt_q == CNTW'(N));
  assign sum_o  = sum_q;
endmodule

// File: rtl/tsense_conv.sv
module tsense_conv
  import tsc_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int CODE_W = 12,
  parameter int N_SAMP = 8,
  parameter int OUT_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sample_valid_i,
  input  logic [IN_W-1:0]  sample_i,
  input  logic [31:0]      cal0_i,
  input  logic [31:0]      cal1_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [OUT_W-1:0] temp_o
);
  localparam int LOG_N = $clog2(N_SAMP);
  localparam int SUM_W = CODE_W + LOG_N;

  conv_state_e state_q, state_d;

  logic [CODE_W-1:0] cal0_q, cal1_q;
  logic [OUT_W-1:0]  corr_q, gain_q, val_q, temp_q;
  logic              done_q, err_q;

  logic [SUM_W-1:0]  acc_sum;
  logic              acc_full, acc_clr, acc_en;
  logic [CODE_W-1:0] avg_w;

  logic              div_start, div_busy, div_done;
  logic [OUT_W-1:0]  div_a, div_b, div_q, div_r;
  logic [OUT_W-1:0]  mag_w, val_w, rnd_w;

  function automatic logic [CODE_W-1:0] cal_pick(input logic [31:0] w, input int unsigned def);
    return w[CAL_VLD] ? w[CODE_W-1:0] : CODE_W'(def);
  endfunction

  assign acc_clr = (state_q == S_IDLE) && start_i;
  assign acc_en  = (state_q == S_COLLECT) && sample_valid_i;
  assign avg_w   = CODE_W'(acc_sum >> LOG_N);

  tsc_acc #(.DW(CODE_W), .N(N_SAMP)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (acc_clr),
    .en_i   (acc_en),
    .data_i (sample_i[CODE_W-1:0]),
    .sum_o  (acc_sum),
    .full_o (acc_full)
  );

  // shared divider operands, selected by phase
  always_comb begin
    div_start = 1'b0;
    div_a     = '0;
    div_b     = 1;
    mag_w     = val_q[OUT_W-1] ? (~val_q + 1'b1) : val_q;
    unique case (state_q)
      S_CORR_GO: begin
        div_start = 1'b1;
        div_a     = OUT_W'(avg_w) * OUT_W'(SCALE);
        div_b     = OUT_W'(SCALE) + OUT_W'(avg_w) * OUT_W'(CURV_K);
      end
      S_GAIN_GO: begin
        div_start = 1'b1;
        div_a     = OUT_W'(SPAN_MC);
        div_b     = OUT_W'(cal0_q) - OUT_W'(cal1_q);
      end
      S_RND_GO: begin
        div_start = 1'b1;
        div_a     = mag_w;
        div_b     = OUT_W'(GRAN_MC);
      end
      default: ;
    endcase
  end

  tsc_div #(.W(OUT_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (div_start),
    .dividend_i (div_a),
    .divisor_i  (div_b),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quot_o     (div_q),
    .rem_o      (div_r)
  );

  assign val_w = (corr_q - OUT_W'(cal1_q)) * gain_q - OUT_W'(OFFS_MC);
  // ceiling to grid: negative adds remainder, positive adds complement
  assign rnd_w = val_q[OUT_W-1] ? (val_q + div_r)
               : (div_r == '0) ? val_q : (val_q + OUT_W'(GRAN_MC) - div_r);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (start_i) state_d = S_COLLECT;
      S_COLLECT: if (acc_full) state_d = (cal0_q == cal1_q) ? S_IDLE : S_CORR_GO;
      S_CORR_GO: state_d = S_CORR_WT;
      S_CORR_WT: if (div_done) state_d = S_GAIN_GO;
      S_GAIN_GO: state_d = S_GAIN_WT;
      S_GAIN_WT: if (div_done) state_d = S_MUL;
      S_MUL:     state_d = S_RND_GO;
      S_RND_GO:  state_d = S_RND_WT;
      S_RND_WT:  if (div_done) state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cal0_q  <= '0;
      cal1_q  <= '0;
      corr_q  <= '0;
      gain_q  <= '0;
      val_q   <= '0;
      temp_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          cal0_q <= cal_pick(cal0_i, DEF_CAL0);
          cal1_q <= cal_pick(cal1_i, DEF_CAL1);
        end
        S_COLLECT: if (acc_full && cal0_q == cal1_q) begin
          done_q <= 1'b1;
          err_q  <= 1'b1;
          temp_q <= '0;
        end
        S_CORR_WT: if (div_done) corr_q <= div_q;
        S_GAIN_WT: if (div_done) gain_q <= div_q;
        S_MUL:     val_q <= val_w;
        S_RND_WT: if (div_done) begin
          done_q <= 1'b1;
          err_q  <= 1'b0;
          temp_q <= rnd_w;
        end
        default: ;
      endcase
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
  assign temp_o = temp_q;
endmodule

// File: rtl/tsense_conv_chk.sv
module tsense_conv_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [31:0] temp_o
);
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idle_at_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(temp_o) && $stable(err_o)));

  p_grid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($signed(temp_o) % 500 == 0));

  p_err_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (temp_o == 32'd0));
endmodule

bind tsense_conv tsense_conv_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .err_o   (err_o),
  .temp_o  (temp_o)
);

// File: tb/tsense_conv_tb.sv
`timescale 1ns/1ps
module tsense_conv_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        sample_valid_i = 1'b0;
  logic [15:0] sample_i = '0;
  logic [31:0] cal0_i = '0;
  logic [31:0] cal1_i = '0;
  logic        busy_o, done_o, err_o;
  logic [31:0] temp_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  tsense_conv u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .sample_valid_i(sample_valid_i), .sample_i(sample_i),
    .cal0_i(cal0_i), .cal1_i(cal1_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .temp_o(temp_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_temp(input logic [15:0] s[8], input logic [31:0] w0, input logic [31:0] w1);
    longint sum = 0;
    longint avg, corr;
    bit [31:0] c0, c1, d, gain, prod;
    int v, r;
    foreach (s[i]) sum += s[i] & 16'h0FFF;
    avg  = sum / 8;
    corr = (avg * 1000000) / (1000000 + 13 * avg);
    c0   = w0[31] ? {20'd0, w0[11:0]} : 32'd3148;
    c1   = w1[31] ? {20'd0, w1[11:0]} : 32'd503;
    d    = c0 - c1;
    gain = 32'd165000 / d;
    prod = (32'(corr) - c1) * gain;
    v    = int'(prod) - 40000;
    r    = v % 500;
    if (r < 0) r += 500;
    return (r == 0) ? v : v + 500 - r;
  endfunction

  // drives a conversion from the current negedge; optional junk strobe on start cycle
  task automatic run(input logic [15:0] s[8], input logic [31:0] w0, input logic [31:0] w1,
                     input bit junk, input bit busy_start, output int t, output bit e, output bit seen);
    cal0_i = w0; cal1_i = w1;
    start_i = 1'b1;
    sample_valid_i = junk; sample_i = 16'h0FFF;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sample_valid_i = 1'b1; sample_i = s[i];
      @(negedge clk_i);
      if (junk) begin
        sample_valid_i = 1'b0; sample_i = 16'h0FFF;
        @(negedge clk_i);
      end
    end
    sample_valid_i = 1'b0;
    seen = 0;
    for (int k = 0; k < 1000; k++) begin
      if (busy_start && k == 5) begin
        start_i = 1'b1; cal0_i = 32'h8000_0100; cal1_i = 32'h8000_0100;
      end else start_i = 1'b0;
      if (done_o) begin seen = 1; break; end
      @(negedge clk_i);
    end
    start_i = 1'b0;
    t = int'(temp_o); e = err_o;
  endtask

  task automatic t_reset;
    chk(busy_o == 0 && done_o == 0 && err_o == 0, "R1 flags", {busy_o, done_o, err_o}, 0);
    chk(temp_o == 0, "R1 temp", temp_o, 0);
  endtask

  task automatic t_basic;
    logic [15:0] s[8] = '{2000, 2000, 2000, 2000, 2000, 2000, 2000, 2000};
    int t; bit e, seen;
    run(s, 32'h0, 32'h0, 0, 0, t, e, seen);
    chk(seen, "R7 done seen", seen, 1);
    chk(t == ref_temp(s, 0, 0) && t == 50000, "R3 R4 R5 default cal", t, ref_temp(s, 0, 0));
    chk(busy_o == 0, "R8 idle at done", busy_o, 0);
    @(negedge clk_i);
    chk(done_o == 0, "R7 pulse width", done_o, 0);
    chk(int'(temp_o) == t, "R7 hold", temp_o, t);
  endtask

  task automatic t_upper_bits;
    logic [15:0] s[8] = '{16'hF7D0, 16'h1801, 16'hA5A5, 16'h0123, 16'h3ABC, 16'hC00F, 16'h0FFE, 16'h8777};
    int t; bit e, seen;
    run(s, 32'h0, 32'h0, 0, 0, t, e, seen);
    chk(t == ref_temp(s, 0, 0), "R2 low bits and truncating average", t, ref_temp(s, 0, 0));
  endtask

  task automatic t_fused;
    logic [15:0] s[8] = '{2000, 2000, 2000, 2000, 2000, 2000, 2000, 2000};
    int t; bit e, seen;
    run(s, 32'h8000_0C00, 32'h8000_01F0, 0, 0, t, e, seen);
    chk(t == 53000, "R5 valid cal words", t, 53000);
    run(s, 32'h0000_0123, 32'h8000_01F0, 0, 0, t, e, seen);
    chk(t == ref_temp(s, 32'h0000_0123, 32'h8000_01F0), "R5 invalid cal0 default", t,
        ref_temp(s, 32'h0000_0123, 32'h8000_01F0));
  endtask

  task automatic t_negative;
    logic [15:0] s[8] = '{100, 100, 100, 100, 100, 100, 100, 100};
    logic [15:0] h[8] = '{3000, 3100, 2900, 3050, 2950, 3001, 2999, 3007};
    int t; bit e, seen;
    run(s, 32'h0, 32'h0, 0, 0, t, e, seen);
    chk(t == -65000, "R6 negative rounds up", t, -65000);
    run(h, 32'h8000_0200, 32'h8000_0900, 0, 0, t, e, seen);
    chk(t == -40000, "R4 cal0 below cal1 gives zero gain", t, -40000);
    run(h, 32'h8000_0B00, 32'h8000_0300, 0, 0, t, e, seen);
    chk(t == ref_temp(h, 32'h8000_0B00, 32'h8000_0300), "R6 positive rounding", t,
        ref_temp(h, 32'h8000_0B00, 32'h8000_0300));
  endtask

  task automatic t_cal_equal;
    logic [15:0] s[8] = '{2000, 2000, 2000, 2000, 2000, 2000, 2000, 2000};
    int t; bit e, seen;
    run(s, 32'h8000_0100, 32'h8000_0100, 0, 0, t, e, seen);
    chk(seen && e == 1, "R9 err flag", e, 1);
    chk(t == 0, "R9 temp zero", t, 0);
    run(s, 32'h0, 32'h0, 0, 0, t, e, seen);
    chk(e == 0 && t == 50000, "R9 err clears", t, 50000);
  endtask

  task automatic t_start_busy;
    logic [15:0] s[8] = '{1500, 1600, 1700, 1800, 1900, 2000, 2100, 2200};
    int t; bit e, seen;
    run(s, 32'h0, 32'h0, 0, 1, t, e, seen);
    chk(t == ref_temp(s, 0, 0) && e == 0, "R8 start while busy ignored", t, ref_temp(s, 0, 0));
    repeat (3) @(negedge clk_i);
    chk(busy_o == 0, "R8 no second conversion", busy_o, 0);
  endtask

  task automatic t_outside;
    logic [15:0] s[8] = '{400, 800, 1200, 1600, 2000, 2400, 2800, 3200};
    int t; bit e, seen;
    sample_valid_i = 1'b1; sample_i = 16'h0FFF;
    repeat (4) @(negedge clk_i);
    run(s, 32'h0, 32'h0, 1, 0, t, e, seen);
    chk(t == ref_temp(s, 0, 0), "R10 strobes outside collection ignored", t, ref_temp(s, 0, 0));
  endtask

  task automatic t_back_to_back;
    logic [15:0] a[8] = '{2000, 2000, 2000, 2000, 2000, 2000, 2000, 2000};
    logic [15:0] b[8] = '{100, 100, 100, 100, 100, 100, 100, 100};
    int t; bit e, seen;
    run(a, 32'h0, 32'h0, 0, 0, t, e, seen);
    // still in the done cycle: start again at once
    run(b, 32'h0, 32'h0, 0, 0, t, e, seen);
    chk(seen && t == -65000, "R8 start in done cycle accepted", t, -65000);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_basic();
    t_upper_bits();
    t_fused();
    t_negative();
    t_cal_equal();
    t_start_busy();
    t_outside();
    t_back_to_back();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule